// File: doc/BRIEF.md
# Maskable Read-Clear Interrupt Controller

This block gathers interrupt events into one eight-bit status view and drives a single active-low interrupt line. Six bits are direct event flags. The two top bits summarize two secondary registers: an extended-cause register and a code-change register. A simple synchronous strobe bus reads and writes the block. Reading the status register clears the direct flags that are visible. A summary bit goes away only when software reads its own secondary register, and that read also empties the register.

Each status bit has a mask bit, and all mask bits are set at reset. A masked direct flag reads as zero in the status view. It is not lost: it stays latched and shows up once its mask bit is cleared. The two summary bits always show in the status view, but while masked they do not drive the interrupt line.

Every bus cycle is decoded into one access kind. The kinds are IDLE, RD_STAT, RD_MASK, RD_EXT, RD_CODE and WR_MASK. A read strobe takes priority over a write strobe. The decoder holds no state, so each cycle is decided afresh from the strobes. It moves from any kind to any other kind on the next strobe pattern.

Top module: `rcirq_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `irq_n_o` is 1, `rdata_o` is 0, every flag is clear and the mask register (address 1) reads 8'hFF.
- R2: A pulse on `src_evt_i[i]` latches direct flag i. A status read (address 0) returns the flag in bit i when mask bit i is 0.
- R3: A status read clears every direct flag whose mask bit is 0. It does not clear bit 7 or bit 6 of the status view.
- R4: A direct flag whose mask bit is 1 reads as 0 and survives status reads. It reads as 1 after its mask bit is written to 0.
- R5: Status bit 7 is 1 while the extended register holds any set bit. Reading address 2 returns that register, then clears it, which also clears status bit 7.
- R6: Status bit 6 is 1 while the code register holds any set bit. Reading address 3 returns that register in the low `N_CODE` bits, with zeros above, then clears it and status bit 6.
- R7: Status bits 7 and 6 read as set even when their mask bits are 1. While masked they do not pull `irq_n_o` low.
- R8: `irq_n_o` is registered. One clock after a cycle in which any status bit is set with a 0 mask bit, it is 0. Otherwise it is 1.
- R9: If an event arrives in the same cycle as the read that would clear its flag, the flag stays set.
- R10: A write to address 1 loads the mask register and a read of address 1 returns it. Writes to any other address have no effect. A read takes priority over a write in the same cycle.
- R11: `rdata_o` is registered. It updates on the clock edge of a read with the value from before that read's clearing, and it holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register address: 0 status, 1 mask, 2 extended, 3 code |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| src_evt_i | input | 6 | Direct event pulses, bit i for status bit i |
| ext_evt_i | input | N_EXT | Extended-cause event pulses |
| code_evt_i | input | N_CODE | Code-change event pulses |
| irq_n_o | output | 1 | Registered active-low interrupt |

## Verification
The assertions check a set of rules on every cycle. A status read leaves no unmasked direct flag behind unless an event arrived with it. A masked flag survives that read. An event always lands. A secondary-register read empties the register. The interrupt line changes only to match the previous cycle's unmasked activity. Other behaviour shows only in the bench scenarios. These cover the sweep of each direct bit under both mask settings, pending flags appearing after unmasking, the summary bits setting while masked without an interrupt, and the priority of an event over a clear in the same cycle. They also cover a read winning over a write, and the data returned by each register address.

// File: rtl/rcirq_pkg.sv
package rcirq_pkg;

    localparam int STAT_W = 8;
    localparam int DIR_W  = STAT_W - 2;
    localparam int BIT_XI = STAT_W - 1;
    localparam int BIT_CC = STAT_W - 2;

    localparam logic [1:0] ADDR_STAT = 2'd0;
    localparam logic [1:0] ADDR_MASK = 2'd1;
    localparam logic [1:0] ADDR_EXT  = 2'd2;
    localparam logic [1:0] ADDR_CODE = 2'd3;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_RD_STAT,
        ACC_RD_MASK,
        ACC_RD_EXT,
        ACC_RD_CODE,
        ACC_WR_MASK
    } acc_e;

endpackage

// File: rtl/rcirq_bus_dec.sv
module rcirq_bus_dec
    import rcirq_pkg::*;
(
    input  logic       rd_i,
    input  logic       wr_i,
    input  logic [1:0] addr_i,
    output acc_e       acc_o
);

    always_comb begin
        acc_o = ACC_IDLE;
        if (rd_i) begin
            unique case (addr_i)
                ADDR_STAT: acc_o = ACC_RD_STAT;
                ADDR_MASK: acc_o = ACC_RD_MASK;
                ADDR_EXT:  acc_o = ACC_RD_EXT;
                ADDR_CODE: acc_o = ACC_RD_CODE;
                default:   acc_o = ACC_IDLE;
            endcase
        end else if (wr_i && addr_i == ADDR_MASK) begin
            acc_o = ACC_WR_MASK;
        end
    end

    // R10: a read strobe never decodes as a write
    always_comb begin
        AST_RD_OVER_WR: assert (!(rd_i && acc_o == ACC_WR_MASK)); // R10
    end

endmodule

// File: rtl/rcirq_rc_reg.sv
module rcirq_rc_reg #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o,
    output logic         any_o
);

    logic [W-1:0] q_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) q_q <= '0;
        else       q_q <= (clr_i ? '0 : q_q) | set_i;
    end

    assign q_o   = q_q;
    assign any_o = |q_q;

    AST_SEC_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> ((q_q & ~$past(set_i)) == '0)); // R5 R6

    AST_SEC_EVT_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
        (|set_i) |=> ((q_q & $past(set_i)) == $past(set_i))); // R9

endmodule

// File: rtl/rcirq_dir_bank.sv
module rcirq_dir_bank
    import rcirq_pkg::*;
#(
    parameter int W = DIR_W,
    parameter int MW = STAT_W
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [W-1:0]  evt_i,
    input  acc_e          acc_i,
    input  logic [MW-1:0] wdata_i,
    output logic [MW-1:0] mask_o,
    output logic [W-1:0]  pend_o
);

    logic [W-1:0]  pend_q;
    logic [MW-1:0] mask_q;
    logic [W-1:0]  clr_vec;

    always_comb begin
        clr_vec = '0;
        unique case (acc_i)
            ACC_RD_STAT: clr_vec = ~mask_q[W-1:0];
            ACC_IDLE, ACC_RD_MASK, ACC_RD_EXT,
            ACC_RD_CODE, ACC_WR_MASK: clr_vec = '0;
            default: clr_vec = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q <= '0;
            mask_q <= '1;
        end else begin
            pend_q <= (pend_q & ~clr_vec) | evt_i;
            if (acc_i == ACC_WR_MASK) mask_q <= wdata_i;
        end
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;

    AST_STAT_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_i == ACC_RD_STAT) |=> ((pend_q & ~$past(mask_q[W-1:0]) & ~$past(evt_i)) == '0)); // R3

    AST_MASKED_KEEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_i == ACC_RD_STAT) |=> ((pend_q & $past(pend_q & mask_q[W-1:0])) == $past(pend_q & mask_q[W-1:0]))); // R4

    AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
        (|evt_i) |=> ((pend_q & $past(evt_i)) == $past(evt_i))); // R9

    AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_i != ACC_WR_MASK) |=> $stable(mask_q)); // R10

endmodule

// File: rtl/rcirq_ctrl.sv
module rcirq_ctrl
    import rcirq_pkg::*;
#(
    parameter int N_EXT  = 8,
    parameter int N_CODE = 3
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [1:0]        addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    input  logic [DIR_W-1:0]  src_evt_i,
    input  logic [N_EXT-1:0]  ext_evt_i,
    input  logic [N_CODE-1:0] code_evt_i,
    output logic              irq_n_o
);

    acc_e               acc;
    logic [STAT_W-1:0]  mask;
    logic [DIR_W-1:0]   pend;
    logic [N_EXT-1:0]   ext_q;
    logic [N_CODE-1:0]  code_q;
    logic               ext_any;
    logic               code_any;
    logic [STAT_W-1:0]  stat_raw;
    logic [STAT_W-1:0]  stat_view;
    logic [STAT_W-1:0]  ext_pad;
    logic [STAT_W-1:0]  code_pad;
    logic [STAT_W-1:0]  rd_mux;
    logic               active;
    logic [7:0]         rdata_q;
    logic               irq_n_q;

    rcirq_bus_dec u_dec (
        .rd_i   (rd_i),
        .wr_i   (wr_i),
        .addr_i (addr_i),
        .acc_o  (acc)
    );

    rcirq_dir_bank #(.W(DIR_W), .MW(STAT_W)) u_bank (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .evt_i   (src_evt_i),
        .acc_i   (acc),
        .wdata_i (wdata_i),
        .mask_o  (mask),
        .pend_o  (pend)
    );

    rcirq_rc_reg #(.W(N_EXT)) u_ext (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .set_i (ext_evt_i),
        .clr_i (acc == ACC_RD_EXT),
        .q_o   (ext_q),
        .any_o (ext_any)
    );

    rcirq_rc_reg #(.W(N_CODE)) u_code (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .set_i (code_evt_i),
        .clr_i (acc == ACC_RD_CODE),
        .q_o   (code_q),
        .any_o (code_any)
    );

    always_comb begin
        stat_raw              = '0;
        stat_raw[DIR_W-1:0]   = pend;
        stat_raw[BIT_CC]      = code_any;
        stat_raw[BIT_XI]      = ext_any;
        stat_view             = stat_raw;
        stat_view[DIR_W-1:0]  = pend & ~mask[DIR_W-1:0];
        active                = |(stat_raw & ~mask);
    end

    always_comb begin
        ext_pad  = '0;
        code_pad = '0;
        for (int i = 0; i < N_EXT; i++)  ext_pad[i]  = ext_q[i];
        for (int i = 0; i < N_CODE; i++) code_pad[i] = code_q[i];
    end

    always_comb begin
        rd_mux = rdata_q;
        unique case (acc)
            ACC_RD_STAT: rd_mux = stat_view;
            ACC_RD_MASK: rd_mux = mask;
            ACC_RD_EXT:  rd_mux = ext_pad;
            ACC_RD_CODE: rd_mux = code_pad;
            ACC_IDLE, ACC_WR_MASK: rd_mux = rdata_q;
            default: rd_mux = rdata_q;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rdata_q <= '0;
            irq_n_q <= 1'b1;
        end else begin
            rdata_q <= rd_mux;
            irq_n_q <= ~active;
        end
    end

    assign rdata_o = rdata_q;
    assign irq_n_o = irq_n_q;

    AST_IRQ_RELEASE: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(irq_n_q) |-> $past((stat_raw & ~mask) == '0)); // R8

    AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(irq_n_q) |-> $past(|(stat_raw & ~mask))); // R8

    AST_SUMMARY_SHOWN: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc == ACC_RD_STAT) |=> (rdata_q[BIT_XI] == $past(ext_any) && rdata_q[BIT_CC] == $past(code_any))); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rd_i) |=> $stable(rdata_q)); // R11

endmodule

// File: tb/rcirq_ctrl_tb.sv
`timescale 1ns/1ps
module rcirq_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       rd, wr;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [5:0] sev;
    logic [7:0] xev;
    logic [2:0] cev;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [5:0] m_dir;
    logic [7:0] m_mask, m_ext;
    logic [2:0] m_code;
    logic [7:0] m_rdata;
    logic       m_irq_n;

    always #2.5 clk = ~clk;

    rcirq_ctrl u_dut (
        .clk_i      (clk),
        .rst_i      (rst),
        .rd_i       (rd),
        .wr_i       (wr),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .src_evt_i  (sev),
        .ext_evt_i  (xev),
        .code_evt_i (cev),
        .irq_n_o    (irq_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [5:0] ev, input logic [7:0] xe, input logic [2:0] ce,
                        input logic r, input logic w, input logic [1:0] a,
                        input logic [7:0] wd, input string tag);
        logic [7:0] view, raw, nrd;
        logic [5:0] clr;
        @(negedge clk);
        sev = ev; xev = xe; cev = ce; rd = r; wr = w; addr = a; wdata = wd;
        @(posedge clk);
        #1;
        raw  = {|m_ext, |m_code, m_dir};
        view = {|m_ext, |m_code, m_dir & ~m_mask[5:0]};
        nrd  = m_rdata;
        if (r) begin
            case (a)
                2'd0: nrd = view;
                2'd1: nrd = m_mask;
                2'd2: nrd = m_ext;
                default: nrd = {5'd0, m_code};
            endcase
        end
        clr = (r && a == 2'd0) ? ~m_mask[5:0] : 6'd0;
        m_irq_n = ~|(raw & ~m_mask);
        m_rdata = nrd;
        m_dir   = (m_dir & ~clr) | ev;
        m_ext   = ((r && a == 2'd2) ? 8'd0 : m_ext) | xe;
        m_code  = ((r && a == 2'd3) ? 3'd0 : m_code) | ce;
        if (!r && w && a == 2'd1) m_mask = wd;
        chk({tag, " rdata"}, rdata, m_rdata);
        chk({tag, " irq"}, {7'd0, irq_n}, {7'd0, m_irq_n});
    endtask

    task automatic idle(input string tag);
        step(6'd0, 8'd0, 3'd0, 1'b0, 1'b0, 2'd0, 8'd0, tag);
    endtask

    task automatic rd_at(input logic [1:0] a, input string tag);
        step(6'd0, 8'd0, 3'd0, 1'b1, 1'b0, a, 8'd0, tag);
    endtask

    task automatic wr_mask(input logic [7:0] v, input string tag);
        step(6'd0, 8'd0, 3'd0, 1'b0, 1'b1, 2'd1, v, tag);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rd = 0; wr = 0; addr = 0; wdata = 0; sev = 0; xev = 0; cev = 0;
        m_dir = 0; m_mask = 8'hFF; m_ext = 0; m_code = 0; m_rdata = 0; m_irq_n = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset rdata", rdata, 8'h00);
        chk("R1 reset irq", {7'd0, irq_n}, 8'h01);
        rd_at(2'd1, "R1 mask reset");
        rd_at(2'd0, "R1 status reset");

        // R2 R3 R4: sweep every direct bit under both mask settings
        for (int i = 0; i < 6; i++) begin
            for (int m = 0; m < 2; m++) begin
                wr_mask(8'hFF & ~(m == 0 ? (8'd1 << i) : 8'd0), "R10 mask write");
                step(6'd1 << i, 8'd0, 3'd0, 1'b0, 1'b0, 2'd0, 8'd0, "R2 event");
                idle("R8 irq follow");
                rd_at(2'd0, "R2 R3 status read");
                rd_at(2'd0, "R4 status reread");
                wr_mask(8'hC0, "R4 unmask");
                idle("R8 irq unmasked");
                rd_at(2'd0, "R4 pending shown");
                rd_at(2'd0, "R3 cleared");
                wr_mask(8'hFF, "R10 remask");
                idle("R8 irq idle");
            end
        end

        // R5 R7: extended register bits, masked then unmasked
        for (int j = 0; j < 8; j++) begin
            step(6'd0, 8'd1 << j, 3'd0, 1'b0, 1'b0, 2'd0, 8'd0, "R5 ext event");
            idle("R7 masked no irq");
            rd_at(2'd0, "R7 summary visible masked");
            rd_at(2'd0, "R3 summary survives status read");
            wr_mask(8'h7F, "R7 unmask xi");
            idle("R7 irq from xi");
            rd_at(2'd2, "R5 ext read");
            rd_at(2'd0, "R5 xi cleared");
            idle("R8 irq release");
            wr_mask(8'hFF, "R10 remask");
        end

        // R6: code register
        for (int k = 0; k < 8; k++) begin
            step(6'd0, 8'd0, k[2:0], 1'b0, 1'b0, 2'd0, 8'd0, "R6 code event");
            wr_mask(8'hBF, "R7 unmask cc");
            idle("R8 irq from cc");
            rd_at(2'd0, "R6 status");
            rd_at(2'd3, "R6 code read");
            rd_at(2'd0, "R6 cc cleared");
            wr_mask(8'hFF, "R10 remask");
        end

        // R9: event in the same cycle as its clearing read
        wr_mask(8'h00, "R10 open all");
        step(6'h05, 8'd0, 3'd0, 1'b0, 1'b0, 2'd0, 8'd0, "R9 prime");
        step(6'h01, 8'd0, 3'd0, 1'b1, 1'b0, 2'd0, 8'd0, "R9 status collide");
        rd_at(2'd0, "R9 status kept");
        step(6'd0, 8'h10, 3'd0, 1'b0, 1'b0, 2'd0, 8'd0, "R9 ext prime");
        step(6'd0, 8'h02, 3'd0, 1'b1, 1'b0, 2'd2, 8'd0, "R9 ext collide");
        rd_at(2'd2, "R9 ext kept");
        step(6'd0, 8'd0, 3'd4, 1'b1, 1'b0, 2'd3, 8'd0, "R9 code collide");
        rd_at(2'd3, "R9 code kept");

        // R10 R11: read beats write; writes elsewhere ignored; rdata holds
        step(6'd0, 8'd0, 3'd0, 1'b1, 1'b1, 2'd1, 8'h5A, "R10 read over write");
        rd_at(2'd1, "R10 mask unchanged");
        step(6'd0, 8'd0, 3'd0, 1'b0, 1'b1, 2'd0, 8'h33, "R10 stray write");
        step(6'd0, 8'd0, 3'd0, 1'b0, 1'b1, 2'd2, 8'h33, "R10 stray write");
        rd_at(2'd1, "R10 mask after stray");
        wr_mask(8'hA5, "R10 write");
        idle("R11 hold");
        rd_at(2'd1, "R10 readback");
        idle("R11 hold after read");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule